// File: doc/BRIEF.md
# Offset-Cancelling Three-Axis Measurement Sequencer

This block runs one complete measurement of a three-axis magnetic bridge sensor front end. On a start strobe it walks the X, Y and Z axes in turn through a single shared ADC port. For each axis it drives the strap and bias controls and takes two averaged acquisitions. It then combines the two acquisitions into one signed result. In the normal configuration the acquisitions follow a set pulse and a reset pulse. Half their difference cancels the bridge offset. In a bias configuration the first acquisition is ambient and the second is taken with a bias current applied. The result is the plain difference.

Each acquisition averages 1, 2, 4 or 8 samples. The samples are summed in a wide accumulator and scaled by an arithmetic shift. A sample flagged out of range, or a bias difference that does not fit, replaces that axis result with a sentinel. The gain code is carried through a two-stage pipeline, so a new gain reaches the ADC only on the second measurement after it is presented. The analog drivers, the converter and any register interface sit outside the block.

Top module: `bridgeMeasSeq`

## Requirements
- R1: With measurement configuration 00 or the reserved code 11, an axis result is floor((avgSet − avgReset) / 2). avgSet is the average of the samples taken after the set pulse, and avgReset is the average of those taken after the reset pulse.
- R2: With configuration 01 (positive) or 10 (negative), an axis result is avgBiased − avgAmbient. During the second acquisition only, biasPos is high for 01 and biasNeg is high for 10. Both stay low at all other times.
- R3: Each axis begins with setPulse high for exactly PULSE_CYC cycles. In normal configuration resetPulse is then high for exactly PULSE_CYC cycles between the two acquisitions. No pulse is given in bias configuration, and adcReq is never high while a pulse is.
- R4: avgSel selects N = 1, 2, 4 or 8 samples per acquisition (codes 00, 01, 10, 11). Each acquisition average is floor(sum / N), computed as an arithmetic right shift.
- R5: Axes are converted in the order X, Y, Z, with 2N samples each. resultX, resultY and resultZ change only when their axis completes. resultValid pulses high for one cycle after all three are written.
- R6: If any sample of an axis arrives with adcOvf high, that axis result is −4096 (0xF000). The other axes are unaffected, and the next measurement without the flag replaces the sentinel.
- R7: In bias configuration, a difference outside −2048..2047 gives the result −4096.
- R8: Results are sign-extended to 16 bits and lie in −2048..2047, or equal the sentinel.
- R9: adcGain holds, for a whole measurement, the gainCode presented at the previously accepted start. After reset it is 001 for the first measurement.
- R10: startReq is ignored while busy. Configuration, averaging and gain are captured only when a start is accepted from idle.
- R11: After reset, busy, adcReq, setPulse, resetPulse, biasPos, biasNeg and resultValid are low, all results are zero and adcGain is 001.
- R12: adcReq stays high until adcAck is seen. A sample is taken only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start one three-axis measurement |
| measCfg | input | 2 | 00 normal, 01 positive bias, 10 negative bias, 11 treated as normal |
| avgSel | input | 2 | Samples per acquisition: 1, 2, 4, 8 |
| gainCode | input | 3 | Requested front-end gain |
| adcAck | input | 1 | ADC sample valid for the current request |
| adcSample | input | 12 | Signed ADC sample |
| adcOvf | input | 1 | Sample out of range |
| setPulse | output | 1 | Set strap drive |
| resetPulse | output | 1 | Reset strap drive |
| biasPos | output | 1 | Positive bias current enable |
| biasNeg | output | 1 | Negative bias current enable |
| adcReq | output | 1 | Sample request |
| adcGain | output | 3 | Gain applied to the front end |
| busy | output | 1 | Measurement in progress |
| resultValid | output | 1 | One-cycle done strobe |
| resultX | output | 16 | Signed X result |
| resultY | output | 16 | Signed Y result |
| resultZ | output | 16 | Signed Z result |

## Verification
The assertions assume that the converter raises adcAck only while adcReq is high. The ADC model in the bench answers only a pending request, after a gap of zero to two cycles, and drops the acknowledge the following cycle. The assertions also take startReq to be a single-cycle strobe. The bench always gives it as one, including the deliberate second start while busy. Samples stay inside the 12-bit signed range, so the averaged values never exceed what the accumulator width covers.

// File: rtl/bmsPkg.sv
package bmsPkg;

  // number of axes and the width of the averaging selector are fixed by the port set
  localparam int AXES      = 3;
  localparam int AVG_SEL_W = 2;
  localparam int AX_W      = 2;

  localparam logic [1:0] CFG_POS = 2'b01;
  localparam logic [1:0] CFG_NEG = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_SETP, S_ACQA, S_LATA, S_RSTP, S_ACQB, S_COMB, S_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 clrAcc;
    logic                 addSmp;
    logic                 holdA;
    logic                 writeRes;
    logic [AX_W-1:0]      axisIdx;
    logic                 biasMode;
    logic [AVG_SEL_W-1:0] shiftAmt;
  } dpCtrl_t;

endpackage

// File: rtl/bmsCtrl.sv
module bmsCtrl
  import bmsPkg::*;
#(
  parameter int PULSE_CYC  = 3,
  parameter int GAIN_W     = 3,
  parameter logic [GAIN_W-1:0] GAIN_RESET = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [1:0]           measCfg,
  input  logic [AVG_SEL_W-1:0] avgSel,
  input  logic [GAIN_W-1:0]    gainCode,
  input  logic                 adcAck,
  output logic                 setPulse,
  output logic                 resetPulse,
  output logic                 biasPos,
  output logic                 biasNeg,
  output logic                 adcReq,
  output logic [GAIN_W-1:0]    adcGain,
  output logic                 busy,
  output logic                 resultValid,
  output dpCtrl_t              dpc
);

  localparam int MAX_SMP = 1 << ((1 << AVG_SEL_W) - 1);
  localparam int CNT_W   = (MAX_SMP > 1) ? $clog2(MAX_SMP) : 1;
  localparam int PCNT_W  = $clog2(PULSE_CYC + 1);
  localparam int RUN_W   = $clog2(PULSE_CYC + 2);

  seqState_t              state, stateNext;
  logic [PCNT_W-1:0]      pulseCnt;
  logic [CNT_W-1:0]       smpCnt, lastIdx;
  logic [AX_W-1:0]        axisCnt;
  logic                   cfgBias, cfgNeg;
  logic [AVG_SEL_W-1:0]   shiftReg;
  logic [GAIN_W-1:0]      activeGain, pendGain;
  logic                   accept, lastSmp, pulseDone, inPulse;

  assign lastIdx   = CNT_W'((1 << shiftReg) - 1);
  assign accept    = adcReq && adcAck;
  assign lastSmp   = (smpCnt == lastIdx);
  assign inPulse   = (state == S_SETP) || (state == S_RSTP);
  assign pulseDone = (pulseCnt == PCNT_W'(PULSE_CYC - 1));

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (startReq) stateNext = S_SETP;
      S_SETP: if (pulseDone) stateNext = S_ACQA;
      S_ACQA: if (accept && lastSmp) stateNext = S_LATA;
      S_LATA: stateNext = cfgBias ? S_ACQB : S_RSTP;
      S_RSTP: if (pulseDone) stateNext = S_ACQB;
      S_ACQB: if (accept && lastSmp) stateNext = S_COMB;
      S_COMB: stateNext = (axisCnt == AX_W'(AXES - 1)) ? S_DONE : S_SETP;
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pulseCnt   <= '0;
      smpCnt     <= '0;
      axisCnt    <= '0;
      cfgBias    <= 1'b0;
      cfgNeg     <= 1'b0;
      shiftReg   <= '0;
      activeGain <= GAIN_RESET;
      pendGain   <= GAIN_RESET;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && startReq) begin
        // reserved code 11 falls into the normal flow
        cfgBias    <= (measCfg == CFG_POS) || (measCfg == CFG_NEG);
        cfgNeg     <= (measCfg == CFG_NEG);
        shiftReg   <= avgSel;
        activeGain <= pendGain;
        pendGain   <= gainCode;
      end
      pulseCnt <= (inPulse && stateNext == state) ? pulseCnt + 1'b1 : '0;
      if (accept)
        smpCnt <= lastSmp ? '0 : smpCnt + 1'b1;
      if (state == S_IDLE)
        axisCnt <= '0;
      else if (state == S_COMB)
        axisCnt <= axisCnt + 1'b1;
    end
  end

  assign setPulse    = (state == S_SETP);
  assign resetPulse  = (state == S_RSTP);
  assign adcReq      = (state == S_ACQA) || (state == S_ACQB);
  assign biasPos     = (state == S_ACQB) && cfgBias && !cfgNeg;
  assign biasNeg     = (state == S_ACQB) && cfgBias && cfgNeg;
  assign busy        = (state != S_IDLE);
  assign resultValid = (state == S_DONE);
  assign adcGain     = activeGain;

  always_comb begin
    dpc          = '0;
    dpc.clrAcc   = (state == S_SETP);
    dpc.addSmp   = accept;
    dpc.holdA    = (state == S_LATA);
    dpc.writeRes = (state == S_COMB);
    dpc.axisIdx  = axisCnt;
    dpc.biasMode = cfgBias;
    dpc.shiftAmt = shiftReg;
  end

  // run length of strap pulses, for the width check
  logic [RUN_W-1:0] pulseRun;
  always_ff @(posedge clk) begin
    if (!rstN) pulseRun <= '0;
    else       pulseRun <= (setPulse || resetPulse) ? pulseRun + 1'b1 : '0;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(setPulse || resetPulse) |-> pulseRun == RUN_W'(PULSE_CYC));
  // R3
  no_req_in_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse || resetPulse) |-> !adcReq && !biasPos && !biasNeg);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcReq && !adcAck |=> adcReq);
  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(cfgBias) && $stable(cfgNeg) && $stable(shiftReg) && $stable(adcGain));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid && !busy);

endmodule

// File: rtl/bmsDatapath.sv
module bmsDatapath
  import bmsPkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dpc,
  input  logic [SAMPLE_W-1:0] adcSample,
  input  logic                adcOvf,
  output logic [RESULT_W-1:0] resultX,
  output logic [RESULT_W-1:0] resultY,
  output logic [RESULT_W-1:0] resultZ
);

  localparam int MAX_SHIFT = (1 << AVG_SEL_W) - 1;
  localparam int ACC_W     = SAMPLE_W + MAX_SHIFT;
  localparam int DIFF_W    = SAMPLE_W + 2;
  localparam logic signed [RESULT_W-1:0] SENTINEL = -(RESULT_W'(1) << SAMPLE_W);
  localparam logic signed [DIFF_W-1:0]   MAX_V    = DIFF_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0]   MIN_V    = -(DIFF_W'(1) << (SAMPLE_W - 1));

  logic signed [ACC_W-1:0]    acc;
  logic                       ovfSeen;
  logic signed [SAMPLE_W-1:0] avgA, avgNow;
  logic signed [DIFF_W-1:0]   extA, extB, diff;
  logic                       biasOvf;
  logic signed [SAMPLE_W-1:0] combVal;
  logic signed [RESULT_W-1:0] resNext;
  logic [RESULT_W-1:0]        res [AXES];

  assign avgNow = SAMPLE_W'(acc >>> dpc.shiftAmt);
  assign extA   = {{(DIFF_W - SAMPLE_W){avgA[SAMPLE_W-1]}}, avgA};
  assign extB   = {{(DIFF_W - SAMPLE_W){avgNow[SAMPLE_W-1]}}, avgNow};
  assign diff   = dpc.biasMode ? (extB - extA) : (extA - extB);
  assign biasOvf = dpc.biasMode && ((diff > MAX_V) || (diff < MIN_V));
  // bias: plain difference, normal: halved by arithmetic shift
  assign combVal = dpc.biasMode ? SAMPLE_W'(diff) : SAMPLE_W'(diff >>> 1);
  assign resNext = (ovfSeen || biasOvf) ? SENTINEL
                 : {{(RESULT_W - SAMPLE_W){combVal[SAMPLE_W-1]}}, combVal};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      ovfSeen <= 1'b0;
      avgA    <= '0;
    end else begin
      if (dpc.clrAcc || dpc.holdA)
        acc <= '0;
      else if (dpc.addSmp)
        acc <= acc + {{(ACC_W - SAMPLE_W){adcSample[SAMPLE_W-1]}}, adcSample};
      if (dpc.clrAcc)
        ovfSeen <= 1'b0;
      else if (dpc.addSmp && adcOvf)
        ovfSeen <= 1'b1;
      if (dpc.holdA)
        avgA <= avgNow;
    end
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rstN)
        res[a] <= '0;
      else if (dpc.writeRes && dpc.axisIdx == AX_W'(a))
        res[a] <= resNext;
    end

    // R6
    ovf_force_chk: assert property (@(posedge clk) disable iff (!rstN)
      dpc.writeRes && dpc.axisIdx == AX_W'(a) && ovfSeen |=> $signed(res[a]) == SENTINEL);
    // R5
    res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(dpc.writeRes && dpc.axisIdx == AX_W'(a)) |=> $stable(res[a]));
    // R8
    res_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($signed(res[a]) >= $signed(RESULT_W'(MIN_V)) && $signed(res[a]) <= $signed(RESULT_W'(MAX_V)))
      || $signed(res[a]) == SENTINEL);
  end

  assign resultX = res[0];
  assign resultY = res[1];
  assign resultZ = res[2];

endmodule

// File: rtl/bridgeMeasSeq.sv
module bridgeMeasSeq
  import bmsPkg::*;
#(
  parameter int PULSE_CYC = 3,
  parameter int SAMPLE_W  = 12,
  parameter int RESULT_W  = 16,
  parameter int GAIN_W    = 3,
  parameter logic [GAIN_W-1:0] GAIN_RESET = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [1:0]           measCfg,
  input  logic [AVG_SEL_W-1:0] avgSel,
  input  logic [GAIN_W-1:0]    gainCode,
  input  logic                 adcAck,
  input  logic [SAMPLE_W-1:0]  adcSample,
  input  logic                 adcOvf,
  output logic                 setPulse,
  output logic                 resetPulse,
  output logic                 biasPos,
  output logic                 biasNeg,
  output logic                 adcReq,
  output logic [GAIN_W-1:0]    adcGain,
  output logic                 busy,
  output logic                 resultValid,
  output logic [RESULT_W-1:0]  resultX,
  output logic [RESULT_W-1:0]  resultY,
  output logic [RESULT_W-1:0]  resultZ
);

  dpCtrl_t dpc;

  bmsCtrl #(
    .PULSE_CYC (PULSE_CYC),
    .GAIN_W    (GAIN_W),
    .GAIN_RESET(GAIN_RESET)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .measCfg    (measCfg),
    .avgSel     (avgSel),
    .gainCode   (gainCode),
    .adcAck     (adcAck),
    .setPulse   (setPulse),
    .resetPulse (resetPulse),
    .biasPos    (biasPos),
    .biasNeg    (biasNeg),
    .adcReq     (adcReq),
    .adcGain    (adcGain),
    .busy       (busy),
    .resultValid(resultValid),
    .dpc        (dpc)
  );

  bmsDatapath #(
    .SAMPLE_W(SAMPLE_W),
    .RESULT_W(RESULT_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpc      (dpc),
    .adcSample(adcSample),
    .adcOvf   (adcOvf),
    .resultX  (resultX),
    .resultY  (resultY),
    .resultZ  (resultZ)
  );

endmodule

// File: tb/test_bridgeMeasSeq.sv
module test_bridgeMeasSeq;
  localparam int PULSE = 3;

  logic clk = 0, rstN = 0, startReq = 0;
  logic [1:0] measCfg = 0, avgSel = 0;
  logic [2:0] gainCode = 0;
  logic adcAck = 0, adcOvf = 0;
  logic [11:0] adcSample = 0;
  logic setPulse, resetPulse, biasPos, biasNeg, adcReq, busy, resultValid;
  logic [2:0] adcGain;
  logic [15:0] resultX, resultY, resultZ;

  bridgeMeasSeq #(.PULSE_CYC(PULSE)) i_bridgeMeasSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .measCfg(measCfg), .avgSel(avgSel),
    .gainCode(gainCode), .adcAck(adcAck), .adcSample(adcSample), .adcOvf(adcOvf),
    .setPulse(setPulse), .resetPulse(resetPulse), .biasPos(biasPos), .biasNeg(biasNeg),
    .adcReq(adcReq), .adcGain(adcGain), .busy(busy), .resultValid(resultValid),
    .resultX(resultX), .resultY(resultY), .resultZ(resultZ));

  always #4 clk = ~clk;

  int total = 0, failed = 0;
  int smp [48];
  bit ovfArr [48];
  int served = 0, gap = 0, nCur = 1, cfgCur = 0;
  int expGain = 1, lastGain = 1;
  int gainErr = 0, biasErr = 0, pulseErr = 0;
  int setCyc = 0, rstCyc = 0, validCyc = 0;
  int unsigned lcg = 32'h1234_5678;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // ADC model: answers a pending request after a short gap
  always @(negedge clk) begin
    if (adcAck) adcAck = 0;
    else if (adcReq) begin
      if (gap > 0) gap--;
      else if (served < 48) begin
        int ph;
        ph = (served / nCur) % 2;
        adcSample = smp[served][11:0];
        adcOvf    = ovfArr[served];
        adcAck    = 1;
        if (int'(adcGain) != expGain) gainErr++;
        if (biasPos != (ph == 1 && cfgCur == 1) || biasNeg != (ph == 1 && cfgCur == 2)) biasErr++;
        if (setPulse || resetPulse) pulseErr++;
        served++;
        gap = served % 3;
      end
    end
    if (setPulse) setCyc++;
    if (resetPulse) rstCyc++;
    if (resultValid) validCyc++;
  end

  function automatic int nextRand();
    lcg = lcg * 1103515245 + 12345;
    return int'((lcg >> 16) % 4096) - 2048;
  endfunction

  function automatic int expAxis(input int a, input int n, input int sh, input bit bias);
    int sa = 0, sb = 0, va, vb, d;
    bit o = 0;
    for (int k = 0; k < n; k++) begin
      sa += smp[a*2*n + k];
      sb += smp[a*2*n + n + k];
      o |= ovfArr[a*2*n + k] | ovfArr[a*2*n + n + k];
    end
    va = sa >>> sh;
    vb = sb >>> sh;
    if (o) return -4096;
    if (bias) begin
      d = vb - va;
      if (d > 2047 || d < -2048) return -4096;
      return d;
    end
    return (va - vb) >>> 1;
  endfunction

  task automatic fillRand();
    for (int i = 0; i < 48; i++) begin smp[i] = nextRand(); ovfArr[i] = 0; end
  endtask

  task automatic runMeas(input int cfg, input int av, input int g, input bit midStart, input string tag);
    int n, e;
    bit bias;
    n = 1 << av;
    bias = (cfg == 1 || cfg == 2);
    nCur = n; cfgCur = cfg; served = 0; gap = 0;
    setCyc = 0; rstCyc = 0; validCyc = 0;
    gainErr = 0; biasErr = 0; pulseErr = 0;
    expGain = lastGain;
    @(negedge clk);
    measCfg = cfg[1:0]; avgSel = av[1:0]; gainCode = g[2:0]; startReq = 1;
    @(negedge clk);
    startReq = 0;
    lastGain = g;
    if (midStart) begin
      repeat (8) @(negedge clk);
      measCfg = ~cfg[1:0]; avgSel = ~av[1:0]; gainCode = ~g[2:0]; startReq = 1;
      @(negedge clk);
      startReq = 0;
    end
    while (!resultValid) @(negedge clk);
    // R1 R2 R4 R5: each axis result against the arithmetic model
    e = expAxis(0, n, av, bias);
    check(int'($signed(resultX)) == e, {tag, " R5 resultX"}, int'($signed(resultX)), e);
    e = expAxis(1, n, av, bias);
    check(int'($signed(resultY)) == e, {tag, " R5 resultY"}, int'($signed(resultY)), e);
    e = expAxis(2, n, av, bias);
    check(int'($signed(resultZ)) == e, {tag, " R5 resultZ"}, int'($signed(resultZ)), e);
    repeat (4) @(negedge clk);
    check(validCyc == 1, {tag, " R5 one done strobe"}, validCyc, 1);
    check(!busy && !adcReq, {tag, " R10 idle after done"}, int'(busy), 0);
    check(served == 6*n, {tag, " R4 sample count"}, served, 6*n);
    check(setCyc == 3*PULSE, {tag, " R3 set cycles"}, setCyc, 3*PULSE);
    check(rstCyc == (bias ? 0 : 3*PULSE), {tag, " R3 reset cycles"}, rstCyc, bias ? 0 : 3*PULSE);
    check(pulseErr == 0, {tag, " R3 pulse during sample"}, pulseErr, 0);
    check(biasErr == 0, {tag, " R2 bias enables"}, biasErr, 0);
    check(gainErr == 0, {tag, " R9 gain at samples"}, gainErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(!busy && !adcReq && !setPulse && !resetPulse && !biasPos && !biasNeg && !resultValid,
          "R11 control outputs", int'(busy), 0);
    check(resultX == 0 && resultY == 0 && resultZ == 0, "R11 results", int'(resultX), 0);
    check(adcGain == 3'b001, "R11 gain", int'(adcGain), 1);

    // R1 R2 R4 R9: sweep every configuration and averaging code
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 4; a++) begin
        fillRand();
        runMeas(c, a, (c*4 + a) % 8, 0, "sweep");
      end

    // R1: full-scale normal difference with eight-sample averages
    for (int i = 0; i < 48; i++) begin
      smp[i] = ((i / 8) % 2 == 0) ? 2047 : -2048;
      ovfArr[i] = 0;
    end
    runMeas(0, 3, 5, 0, "R1 full scale");

    // R7: X overflows, Y and Z sit on the valid edges
    for (int k = 0; k < 2; k++) begin
      smp[k] = -2048;  smp[2+k] = 2047;
      smp[4+k] = 0;    smp[6+k] = 2047;
      smp[8+k] = 2047; smp[10+k] = -1;
    end
    for (int i = 0; i < 48; i++) ovfArr[i] = 0;
    runMeas(1, 1, 2, 0, "R7 bias limits");
    for (int k = 0; k < 2; k++) begin
      smp[k] = 2047; smp[2+k] = -2048;
    end
    runMeas(2, 1, 2, 0, "R7 negative");

    // R6: one flagged sample on Y only, then a clean measurement replaces it
    fillRand();
    ovfArr[4*2 + 5] = 1;
    runMeas(0, 2, 3, 0, "R6 flagged");
    fillRand();
    runMeas(0, 2, 4, 0, "R6 recovery");

    // R10: a second start while busy changes nothing
    fillRand();
    runMeas(3, 1, 6, 1, "R10 start while busy");
    fillRand();
    runMeas(1, 0, 0, 0, "R9 after ignored start");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule